// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block drives the write side of an on-chip flash array. It can program one byte, erase one 512-byte page, or erase the whole array. Software first stores the system clock rate in kHz, written as two byte-wide registers. It then loads the page number, the byte offset and the data byte. To start an operation it opens a two-step key sequence on the control register and writes a command code there. The block then raises one array strobe and holds it for a fixed span of real time. The number of clocks in that span comes from the stored kHz value, so the span stays the same at any clock rate that software declares.

Every operation needs the key sequence first. Any stray write during the sequence closes it again. The block also locks again whenever a command is written. A command is refused if the stored clock value is outside the range where pulse timing is supported. While an operation runs, register writes are dropped. A one-cycle completion pulse marks the end of each operation.

Top module: `flash_seq_ctrl`

## Requirements
- R1: The clock-rate value is 16 bits wide. Its high byte is written at register address 0 and its low byte at address 1. Both bytes read back at the same addresses.
- R2: Writing 0x73 and then 0x8C to the control register (address 2) opens the controller, and status bit 2 reads 1. If any other write comes between the two, the controller stays locked.
- R3: A command code written while the controller is locked is dropped. No strobe rises and status stays 0.
- R4: While the controller is open, a control write of 0x01 starts a byte program, 0x02 starts a page erase and 0x03 starts a mass erase. Any control write locks the controller again. A value that is not a command only locks it.
- R5: A command issued while the clock-rate value lies outside 20 to 20000 is refused. The refusal sets status bit 1 and raises no strobe. An accepted command clears status bit 1.
- R6: The strobe rises in the cycle after the command write. It stays high for exactly ceil(D*F/1000) cycles, where D is the operation's duration in microseconds and F is the clock-rate value.
- R7: The array address is {page, offset} for a byte program, {page, 9'b0} for a page erase and 0 for a mass erase. The data output carries the data register (address 6) during a program. The page is at address 3, offset bits 7:0 at address 4 and offset bit 8 at address 5 bit 0. The address does not change during a pulse.
- R8: busy_o and status bit 0 are high from the cycle after acceptance until the pulse ends. Register writes made while busy have no effect.
- R9: done_o pulses for one cycle, in the first cycle after the strobe falls. The controller is locked at that point.
- R10: After reset, all registers read 0, the controller is locked and no strobe, busy or done is active.
- R11: At most one of the three array strobes is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address (7 = status) |
| rd_data | output | 8 | Register read data, combinational |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| prog_o | output | 1 | Byte program strobe |
| erase_o | output | 1 | Page erase strobe |
| mass_o | output | 1 | Mass erase strobe |
| fl_addr_o | output | 17 | Array address |
| fl_data_o | output | 8 | Array program data |

## Verification
The properties assume that wr_en, wr_addr and wr_data change only away from the rising clock edge and are never unknown after reset. They also assume that software does not change the clock-rate value in a way that invalidates a pulse already in flight. The block makes this safe by freezing its registers while busy. The stimulus drives all inputs on falling edges. It draws clock-rate values mostly from the legal range, and only sometimes from just outside it. It keeps the durations small, so that the worst legal pulse fits in a few thousand cycles.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  localparam logic [2:0] A_FHI  = 3'd0;
  localparam logic [2:0] A_FLO  = 3'd1;
  localparam logic [2:0] A_CTL  = 3'd2;
  localparam logic [2:0] A_PAGE = 3'd3;
  localparam logic [2:0] A_OFSL = 3'd4;
  localparam logic [2:0] A_OFSH = 3'd5;
  localparam logic [2:0] A_DATA = 3'd6;
  localparam logic [2:0] A_STAT = 3'd7;

  localparam logic [7:0] KEY_FIRST  = 8'h73;
  localparam logic [7:0] KEY_SECOND = 8'h8C;
  localparam logic [7:0] CMD_PROG   = 8'h01;
  localparam logic [7:0] CMD_PAGE   = 8'h02;
  localparam logic [7:0] CMD_MASS   = 8'h03;

  // kHz-scaled elapsed time gained per clock: one clock lasts 1000/F microseconds
  localparam int unsigned STEP_PER_CLK = 1000;

  typedef enum logic [1:0] {OP_PROG, OP_PAGE, OP_MASS} op_e;
  typedef enum logic [1:0] {LK_SHUT, LK_HALF, LK_OPEN} lock_e;

  function automatic logic is_cmd(input logic [7:0] v);
    return (v == CMD_PROG) || (v == CMD_PAGE) || (v == CMD_MASS);
  endfunction

  function automatic op_e cmd_to_op(input logic [7:0] v);
    case (v)
      CMD_PAGE: return OP_PAGE;
      CMD_MASS: return OP_MASS;
      default:  return OP_PROG;
    endcase
  endfunction

  function automatic logic freq_in_range(input logic [15:0] f, input int unsigned lo,
                                         input int unsigned hi);
    return (32'(f) >= lo) && (32'(f) <= hi);
  endfunction

endpackage

// File: rtl/fsc_lock.sv
module fsc_lock
  import fsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ok,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       open_o,
  output logic       cmd_fire_o,
  output op_e        cmd_op_o
);

  lock_e st;
  logic  ctl_wr;

  assign ctl_wr = wr_ok && (wr_addr == A_CTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= LK_SHUT;
    end else if (wr_ok) begin
      case (st)
        LK_SHUT: st <= (ctl_wr && wr_data == KEY_FIRST)  ? LK_HALF : LK_SHUT;
        LK_HALF: st <= (ctl_wr && wr_data == KEY_SECOND) ? LK_OPEN : LK_SHUT;
        LK_OPEN: st <= ctl_wr ? LK_SHUT : LK_OPEN;
        default: st <= LK_SHUT;
      endcase
    end
  end

  assign open_o     = (st == LK_OPEN);
  assign cmd_fire_o = ctl_wr && (st == LK_OPEN) && is_cmd(wr_data);
  assign cmd_op_o   = cmd_to_op(wr_data);

endmodule

// File: rtl/fsc_timer.sv
module fsc_timer #(
  parameter int unsigned TGT_W = 34,
  parameter int unsigned STEP  = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TGT_W-1:0] target,
  output logic             busy_o,
  output logic             finish_o
);

  logic [TGT_W-1:0] acc;
  logic [TGT_W-1:0] tgt;
  logic [TGT_W-1:0] acc_next;

  assign acc_next = acc + TGT_W'(STEP);
  assign finish_o = busy_o && (acc_next >= tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      acc    <= '0;
      tgt    <= '0;
    end else if (start) begin
      busy_o <= 1'b1;
      acc    <= '0;
      tgt    <= target;
    end else if (busy_o) begin
      acc <= acc_next;
      if (finish_o) busy_o <= 1'b0;
    end
  end

endmodule

// File: rtl/fsc_drive.sv
module fsc_drive
  import fsc_pkg::*;
#(
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned OFS_W  = 9,
  localparam int unsigned ADDR_W = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  op_e               op_in,
  input  logic [PAGE_W-1:0] page_in,
  input  logic [OFS_W-1:0]  ofs_in,
  input  logic [7:0]        data_in,
  input  logic              busy,
  output logic              prog_o,
  output logic              erase_o,
  output logic              mass_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        data_o
);

  op_e               op_q;
  logic [PAGE_W-1:0] page_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [7:0]        data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_PROG;
      page_q <= '0;
      ofs_q  <= '0;
      data_q <= '0;
    end else if (load) begin
      op_q   <= op_in;
      page_q <= page_in;
      ofs_q  <= ofs_in;
      data_q <= data_in;
    end
  end

  always_comb begin
    case (op_q)
      OP_PROG: addr_o = {page_q, ofs_q};
      OP_PAGE: addr_o = {page_q, {OFS_W{1'b0}}};
      default: addr_o = '0;
    endcase
  end

  assign data_o  = (op_q == OP_PROG) ? data_q : 8'hFF;
  assign prog_o  = busy && (op_q == OP_PROG);
  assign erase_o = busy && (op_q == OP_PAGE);
  assign mass_o  = busy && (op_q == OP_MASS);

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import fsc_pkg::*;
#(
  parameter int unsigned PROG_US  = 40,
  parameter int unsigned PAGE_US  = 10000,
  parameter int unsigned MASS_US  = 200000,
  parameter int unsigned PAGE_W   = 8,
  parameter int unsigned OFS_W    = 9,
  parameter int unsigned FREQ_MIN = 20,
  parameter int unsigned FREQ_MAX = 20000,
  localparam int unsigned ADDR_W  = PAGE_W + OFS_W,
  localparam int unsigned DUR_MAX = (MASS_US > PAGE_US)
                                    ? ((MASS_US > PROG_US) ? MASS_US : PROG_US)
                                    : ((PAGE_US > PROG_US) ? PAGE_US : PROG_US),
  localparam int unsigned DUR_W   = $clog2(DUR_MAX + 1),
  localparam int unsigned TGT_W   = DUR_W + 16,
  localparam int unsigned OFS_HI_W = OFS_W - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [2:0]        rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy_o,
  output logic              done_o,
  output logic              prog_o,
  output logic              erase_o,
  output logic              mass_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_data_o
);

  logic [7:0]          freq_hi, freq_lo, page_q, ofs_lo, data_q;
  logic [OFS_HI_W-1:0] ofs_hi;
  logic                err_q;
  logic [15:0]         freq_val;
  logic                wr_ok;
  logic                unlocked;
  logic                cmd_fire;
  op_e                 cmd_op;
  logic                freq_ok;
  logic                cmd_accept;
  logic                cmd_reject;
  logic                op_finish;
  logic [DUR_W-1:0]    dur_sel;
  logic [TGT_W-1:0]    pulse_tgt;

  function automatic logic [TGT_W-1:0] scaled_target(input logic [DUR_W-1:0] dur_us,
                                                     input logic [15:0] f_khz);
    return TGT_W'(dur_us) * TGT_W'(f_khz);
  endfunction

  assign freq_val   = {freq_hi, freq_lo};
  assign wr_ok      = wr_en && !busy_o;
  assign freq_ok    = freq_in_range(freq_val, FREQ_MIN, FREQ_MAX);
  assign cmd_accept = cmd_fire && freq_ok;
  assign cmd_reject = cmd_fire && !freq_ok;

  always_comb begin
    case (cmd_op)
      OP_PAGE: dur_sel = DUR_W'(PAGE_US);
      OP_MASS: dur_sel = DUR_W'(MASS_US);
      default: dur_sel = DUR_W'(PROG_US);
    endcase
  end

  assign pulse_tgt = scaled_target(dur_sel, freq_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_hi <= '0;
      freq_lo <= '0;
      page_q  <= '0;
      ofs_lo  <= '0;
      ofs_hi  <= '0;
      data_q  <= '0;
    end else if (wr_ok) begin
      case (wr_addr)
        A_FHI:  freq_hi <= wr_data;
        A_FLO:  freq_lo <= wr_data;
        A_PAGE: page_q  <= wr_data;
        A_OFSL: ofs_lo  <= wr_data;
        A_OFSH: ofs_hi  <= wr_data[OFS_HI_W-1:0];
        A_DATA: data_q  <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= op_finish;
      if (cmd_accept)      err_q <= 1'b0;
      else if (cmd_reject) err_q <= 1'b1;
    end
  end

  always_comb begin
    case (rd_addr)
      A_FHI:  rd_data = freq_hi;
      A_FLO:  rd_data = freq_lo;
      A_PAGE: rd_data = page_q;
      A_OFSL: rd_data = ofs_lo;
      A_OFSH: rd_data = 8'(ofs_hi);
      A_DATA: rd_data = data_q;
      A_STAT: rd_data = {5'b0, unlocked, err_q, busy_o};
      default: rd_data = 8'h00;
    endcase
  end

  fsc_lock i_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ok      (wr_ok),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .open_o     (unlocked),
    .cmd_fire_o (cmd_fire),
    .cmd_op_o   (cmd_op)
  );

  fsc_timer #(.TGT_W(TGT_W), .STEP(STEP_PER_CLK)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cmd_accept),
    .target   (pulse_tgt),
    .busy_o   (busy_o),
    .finish_o (op_finish)
  );

  fsc_drive #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) i_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cmd_accept),
    .op_in   (cmd_op),
    .page_in (page_q[PAGE_W-1:0]),
    .ofs_in  ({ofs_hi, ofs_lo}),
    .data_in (data_q),
    .busy    (busy_o),
    .prog_o  (prog_o),
    .erase_o (erase_o),
    .mass_o  (mass_o),
    .addr_o  (fl_addr_o),
    .data_o  (fl_data_o)
  );

endmodule

// File: rtl/fsc_check.sv
module fsc_check #(
  parameter int unsigned ADDR_W   = 17,
  parameter int unsigned FREQ_MIN = 20,
  parameter int unsigned FREQ_MAX = 20000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              prog,
  input logic              erase,
  input logic              mass,
  input logic              accept,
  input logic              reject,
  input logic              unlocked,
  input logic [15:0]       freq,
  input logic [ADDR_W-1:0] addr
);

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog, erase, mass})); // R11

  AST_REJECT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> !busy); // R5

  AST_ACCEPT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (32'(freq) >= FREQ_MIN && 32'(freq) <= FREQ_MAX)); // R5

  AST_BUSY_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(accept)); // R8

  AST_FREQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(freq)); // R8

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr)); // R7

  AST_DONE_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R9

  AST_RELOCK_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !unlocked); // R9

endmodule

bind flash_seq_ctrl fsc_check #(
  .ADDR_W   (ADDR_W),
  .FREQ_MIN (FREQ_MIN),
  .FREQ_MAX (FREQ_MAX)
) i_check (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy_o),
  .done     (done_o),
  .prog     (prog_o),
  .erase    (erase_o),
  .mass     (mass_o),
  .accept   (cmd_accept),
  .reject   (cmd_reject),
  .unlocked (unlocked),
  .freq     (freq_val),
  .addr     (fl_addr_o)
);

// File: tb/test_flash_seq_ctrl.sv
module test_flash_seq_ctrl;

  localparam int unsigned P_US = 4;
  localparam int unsigned E_US = 20;
  localparam int unsigned M_US = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        busy_o, done_o, prog_o, erase_o, mass_o;
  logic [16:0] fl_addr_o;
  logic [7:0]  fl_data_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flash_seq_ctrl #(.PROG_US(P_US), .PAGE_US(E_US), .MASS_US(M_US)) i_flash_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy_o(busy_o), .done_o(done_o),
    .prog_o(prog_o), .erase_o(erase_o), .mass_o(mass_o),
    .fl_addr_o(fl_addr_o), .fl_data_o(fl_data_o)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint exp_cycles(input int unsigned dur, input int unsigned f);
    return (longint'(dur) * f + 999) / 1000;
  endfunction

  function automatic int unsigned dur_of(input logic [7:0] cmd);
    return (cmd == 8'h01) ? P_US : (cmd == 8'h02) ? E_US : M_US;
  endfunction

  function automatic logic [2:0] strobe_of(input logic [7:0] cmd);
    return (cmd == 8'h01) ? 3'b001 : (cmd == 8'h02) ? 3'b010 : 3'b100;
  endfunction

  function automatic logic [16:0] addr_of(input logic [7:0] cmd, input logic [7:0] pg,
                                          input logic [8:0] ofs);
    if (cmd == 8'h01) return {pg, ofs};
    if (cmd == 8'h02) return {pg, 9'd0};
    return 17'd0;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic unlock();
    wr(3'd2, 8'h73);
    wr(3'd2, 8'h8C);
  endtask

  task automatic run_cmd(input logic [7:0] cmd, input logic [15:0] f, input logic [7:0] pg,
                         input logic [8:0] ofs, input logic [7:0] dat);
    logic [7:0] st;
    longint n;
    bit addr_bad;
    bit legal;
    wr(3'd0, f[15:8]);
    wr(3'd1, f[7:0]);
    wr(3'd3, pg);
    wr(3'd4, ofs[7:0]);
    wr(3'd5, {7'd0, ofs[8]});
    wr(3'd6, dat);
    unlock();
    wr(3'd2, cmd);
    legal = (f >= 16'd20) && (f <= 16'd20000);
    if (!legal) begin
      check("R5 refused command raises no strobe", {mass_o, erase_o, prog_o}, 0);
      rd(3'd7, st);
      check("R5 refused command sets error bit", st[1], 1);
      check("R8 refused command not busy", busy_o, 0);
    end else begin
      check("R11 strobe select", {mass_o, erase_o, prog_o}, strobe_of(cmd));
      if (cmd == 8'h01) check("R7 program data", fl_data_o, dat);
      n = 0;
      addr_bad = 0;
      while ((prog_o || erase_o || mass_o) && n < 5000) begin
        if (fl_addr_o != addr_of(cmd, pg, ofs)) addr_bad = 1;
        n++;
        @(negedge clk);
      end
      check("R6 pulse length", n, exp_cycles(dur_of(cmd), f));
      check("R7 array address held", addr_bad, 0);
      check("R9 done after pulse", done_o, 1);
      rd(3'd7, st);
      check("R9 relocked and R5 error cleared", st, 8'h00);
      @(negedge clk);
      check("R9 done lasts one cycle", done_o, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R10 register reset value", v, 0);
    end
    check("R10 outputs idle", {busy_o, done_o, prog_o, erase_o, mass_o}, 0);

    // R1 frequency bytes read back
    wr(3'd0, 8'h12);
    wr(3'd1, 8'h34);
    rd(3'd0, v); check("R1 high byte", v, 8'h12);
    rd(3'd1, v); check("R1 low byte", v, 8'h34);

    // R3 command while locked
    wr(3'd2, 8'h01);
    check("R3 locked command no strobe", {busy_o, prog_o, erase_o, mass_o}, 0);
    rd(3'd7, v); check("R3 locked command status", v, 0);

    // R2 interrupted key sequence
    wr(3'd2, 8'h73);
    wr(3'd3, 8'h05);
    wr(3'd2, 8'h8C);
    rd(3'd7, v); check("R2 interrupted sequence stays locked", v[2], 0);
    unlock();
    rd(3'd7, v); check("R2 full sequence opens", v[2], 1);

    // R4 non-command value relocks without starting
    wr(3'd2, 8'h55);
    rd(3'd7, v); check("R4 non-command relocks", v, 0);
    check("R4 non-command no strobe", {prog_o, erase_o, mass_o}, 0);

    // R5 boundaries of clock-rate range
    run_cmd(8'h01, 16'd19, 8'h01, 9'h001, 8'h5A);
    run_cmd(8'h01, 16'd20, 8'h02, 9'h1FF, 8'hA5);
    run_cmd(8'h02, 16'd20001, 8'h03, 9'h000, 8'h00);
    run_cmd(8'h02, 16'd20000, 8'hFF, 9'h0AB, 8'h00);
    run_cmd(8'h03, 16'd1000, 8'h00, 9'h000, 8'h00);

    // R8 writes during busy are dropped
    wr(3'd0, 8'h03);
    wr(3'd1, 8'hE8);
    wr(3'd3, 8'h21);
    unlock();
    wr(3'd2, 8'h03);
    rd(3'd7, v); check("R8 status busy bit", v[0], 1);
    check("R8 busy output", busy_o, 1);
    wr(3'd0, 8'hAA);
    wr(3'd3, 8'h77);
    wr(3'd2, 8'h73);
    while (busy_o) @(negedge clk);
    rd(3'd0, v); check("R8 freq write during busy dropped", v, 8'h03);
    rd(3'd3, v); check("R8 page write during busy dropped", v, 8'h21);
    wr(3'd2, 8'h8C);
    rd(3'd7, v); check("R8 key during busy dropped", v[2], 0);

    // random mix
    for (int i = 0; i < 24; i++) begin
      logic [15:0] f;
      logic [7:0] cmd;
      if ($urandom % 8 == 0)
        f = ($urandom % 2 == 0) ? 16'($urandom % 20) : 16'(20001 + $urandom % 1000);
      else
        f = 16'(20 + $urandom % 1981);
      cmd = 8'(1 + $urandom % 3);
      run_cmd(cmd, f, 8'($urandom), 9'($urandom), 8'($urandom));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule